// File: doc/BRIEF.md
# Floating-Point Mantissa Rounder

This unit takes an unpacked floating-point significand that still carries two extra low-order bits (guard and round) and a separate sticky bit, and produces the significand at its final width. The two extra bits are always dropped. The value is incremented or left alone according to a 2-bit rounding-mode field and the sign of the operand. The unit sits between an arithmetic datapath and a result packer.

Alongside the rounded significand it reports two flags. The inexact flag is set when any discarded bit was nonzero. The rounded-up flag is set whenever an increment took place. A carry out of the top bit can leave the value at 2.0. The unit does not renormalise that value; the packer uses the rounded-up flag and the top bit to detect it, or to detect a subnormal that rounded up to a normal.

A parameter selects between two forms. In the purely combinational form the outputs follow the inputs in the same cycle. In the registered form they appear one clock later.

Top module: `mant_rounder`

## Requirements
- R1: The output significand is the input significand (width MW, with guard at bit 1 and round at bit 0 of the extended word {mant, guard, round}) shifted right by two. An increment is then added when the mode calls for one.
- R2: When guard, round and sticky are all zero, the output equals the input significand unchanged, and both flags are 0 whatever the mode.
- R3: `inexact` is 1 exactly when at least one of guard, round or sticky is 1, in every mode.
- R4: Mode 0 (nearest, ties to even) increments only when guard is 1 and at least one of the following is 1: round, sticky, or bit 0 of the input significand.
- R5: Mode 1 (toward zero) never increments.
- R6: Mode 2 (toward +infinity) increments only when the result is inexact and sign is 0.
- R7: Mode 3 (toward -infinity) increments only when the result is inexact and sign is 1.
- R8: The increment carries through the whole significand. An all-ones input that rounds up gives all zeros with `carry_out` = 1, which represents the value 2.0. Otherwise `carry_out` is 0.
- R9: `rounded_up` is 1 exactly when an increment was applied.
- R10: With REGISTERED = 1, outputs reflect the inputs sampled at the previous rising edge, and are all zero while `rst_n` is low. With REGISTERED = 0, outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when REGISTERED = 1 |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| mant_in | input | MW | Significand before rounding, guard/round excluded |
| guard_in | input | 1 | First bit below the significand LSB |
| round_in | input | 1 | Second bit below the significand LSB |
| sticky_in | input | 1 | OR of all lower discarded bits |
| sign_in | input | 1 | Operand sign, 1 = negative |
| mode_in | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_out | output | MW | Rounded significand |
| carry_out | output | 1 | Carry out of the increment (value became 2.0) |
| rounded_up | output | 1 | An increment was applied |
| inexact | output | 1 | Any discarded bit was nonzero |

## Verification
The assertions assume the inputs are held stable from one clock edge to the next. This matters because the checker compares registered outputs against `$past` of the inputs. The assertions also assume that every 2-bit mode code is legal, so no input needs to be excluded. The bench changes inputs only on falling edges, which keeps them within that assumption. It draws the significand, the low bits, the sign and the mode from a fixed-seed generator. It adds directed cases: all-ones carry, exact inputs, and ties with even and odd LSBs.

// File: rtl/mant_rounder.sv
module mant_rounder #(
  parameter int MW = 24,
  parameter bit REGISTERED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mant_in,
  input  logic          guard_in,
  input  logic          round_in,
  input  logic          sticky_in,
  input  logic          sign_in,
  input  logic [1:0]    mode_in,
  output logic [MW-1:0] mant_out,
  output logic          carry_out,
  output logic          rounded_up,
  output logic          inexact
);
  localparam logic [1:0] MODE_NEAR = 2'd0;
  localparam logic [1:0] MODE_ZERO = 2'd1;
  localparam logic [1:0] MODE_PINF = 2'd2;
  localparam logic [1:0] MODE_NINF = 2'd3;

  logic          lost;
  logic          bump;
  logic [MW:0]   sum;

  assign lost = guard_in | round_in | sticky_in;

  always_comb begin
    bump = 1'b0;
    if (lost) begin
      unique case (mode_in)
        MODE_NEAR: bump = guard_in & (round_in | sticky_in | mant_in[0]);
        MODE_ZERO: bump = 1'b0;
        MODE_PINF: bump = ~sign_in;
        MODE_NINF: bump = sign_in;
        default:   bump = 1'b0;
      endcase
    end
  end

  assign sum = {1'b0, mant_in} + {{MW{1'b0}}, bump};

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mant_out   <= '0;
          carry_out  <= 1'b0;
          rounded_up <= 1'b0;
          inexact    <= 1'b0;
        end else begin
          mant_out   <= sum[MW-1:0];
          carry_out  <= sum[MW];
          rounded_up <= bump;
          inexact    <= lost;
        end
      end
    end else begin : g_comb
      assign mant_out   = sum[MW-1:0];
      assign carry_out  = sum[MW];
      assign rounded_up = bump;
      assign inexact    = lost;
    end
  endgenerate
endmodule

// File: rtl/mant_rounder_chk.sv
module mant_rounder_chk #(
  parameter int MW = 24,
  parameter bit REGISTERED = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW-1:0] mant_in,
  input logic          guard_in,
  input logic          round_in,
  input logic          sticky_in,
  input logic          sign_in,
  input logic [1:0]    mode_in,
  input logic [MW-1:0] mant_out,
  input logic          carry_out,
  input logic          rounded_up,
  input logic          inexact
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  generate
    if (REGISTERED) begin : g_r
      assert_inexact_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        inexact == ($past(guard_in) | $past(round_in) | $past(sticky_in)));
      assert_exact_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !inexact |-> (!rounded_up && mant_out == $past(mant_in)));
      assert_rz_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(mode_in) == 2'd1) |-> !rounded_up);
      assert_dir_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (rounded_up && $past(mode_in) == 2'd2) |-> !$past(sign_in));
      assert_dir_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (rounded_up && $past(mode_in) == 2'd3) |-> $past(sign_in));
      assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        {carry_out, mant_out} == {1'b0, $past(mant_in)} + (MW+1)'(rounded_up));
      assert_carry_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        carry_out |-> (rounded_up && mant_out == '0));
    end else begin : g_c
      always_comb begin
        if (rst_n) begin
          assert_inexact_R3: assert (inexact == (guard_in | round_in | sticky_in));
          assert_step_R9: assert ({carry_out, mant_out} == {1'b0, mant_in} + (MW+1)'(rounded_up));
          assert_rz_R5: assert (!(mode_in == 2'd1 && rounded_up));
          assert_carry_R8: assert (!carry_out || (rounded_up && mant_out == '0));
        end
      end
    end
  endgenerate
endmodule

bind mant_rounder mant_rounder_chk #(.MW(MW), .REGISTERED(REGISTERED)) u_chk (.*);

// File: tb/tb_mant_rounder.sv
`timescale 1ns/1ps
module tb_mant_rounder;
  localparam int MW = 24;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MW-1:0] mant_in = '0;
  logic g = 0, r = 0, s = 0, sg = 0;
  logic [1:0] mode = 0;
  logic [MW-1:0] mant_out;
  logic carry_out, rounded_up, inexact;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  mant_rounder #(.MW(MW), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .guard_in(g), .round_in(r),
    .sticky_in(s), .sign_in(sg), .mode_in(mode), .mant_out(mant_out),
    .carry_out(carry_out), .rounded_up(rounded_up), .inexact(inexact));

  function automatic logic want_bump(logic [MW-1:0] m, logic gg, logic rr, logic ss,
                                     logic sn, logic [1:0] md);
    if (!(gg | rr | ss)) return 1'b0;
    case (md)
      2'd0: return gg && (rr || ss || m[0]);
      2'd1: return 1'b0;
      2'd2: return !sn;
      default: return sn;
    endcase
  endfunction

  task automatic apply(input logic [MW-1:0] m, input logic gg, rr, ss, sn,
                       input logic [1:0] md, input string tag);
    logic b;
    logic [MW:0] e;
    @(negedge clk);
    mant_in = m; g = gg; r = rr; s = ss; sg = sn; mode = md;
    b = want_bump(m, gg, rr, ss, sn, md);
    e = {1'b0, m} + (MW+1)'(b);
    @(negedge clk);
    nvec++;
    if ({carry_out, mant_out} !== e || rounded_up !== b || inexact !== (gg | rr | ss)) begin
      nbad++;
      $display("FAIL %s: got c=%0b m=%h up=%0b nx=%0b exp c=%0b m=%h up=%0b nx=%0b",
               tag, carry_out, mant_out, rounded_up, inexact, e[MW], e[MW-1:0], b, gg|rr|ss);
    end
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog R10: got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mant_in = '1; g = 1; r = 1; s = 1; mode = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nvec++;
    if (mant_out !== '0 || carry_out || rounded_up || inexact) begin
      nbad++;
      $display("FAIL R10 reset: got m=%h c=%0b up=%0b nx=%0b exp all 0",
               mant_out, carry_out, rounded_up, inexact);
    end
    rst_n = 1'b1;
    for (int md = 0; md < 4; md++) apply(24'h123455, 0, 0, 0, md[0], 2'(md), "R2 exact");
    apply(24'h000010, 1, 0, 0, 0, 0, "R4 tie even");
    apply(24'h000011, 1, 0, 0, 0, 0, "R4 tie odd");
    apply(24'h000010, 1, 0, 1, 0, 0, "R4 above half");
    apply(24'h000011, 0, 1, 1, 0, 0, "R4 below half R3");
    apply(24'h0000ff, 1, 1, 1, 1, 1, "R5 toward zero");
    apply(24'h000100, 0, 0, 1, 0, 2, "R6 pos up");
    apply(24'h000100, 0, 0, 1, 1, 2, "R6 neg down");
    apply(24'h000100, 0, 1, 0, 1, 3, "R7 neg up");
    apply(24'h000100, 0, 1, 0, 0, 3, "R7 pos down");
    apply('1, 1, 1, 0, 0, 0, "R8 carry to 2.0 R9");
    apply('1, 0, 0, 1, 1, 3, "R8 carry minus R1");
    apply(24'h7fffff, 1, 1, 0, 0, 0, "R8 internal carry");
    for (int i = 0; i < 3000; i++)
      apply(MW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), "R1 random");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule